// File: doc/BRIEF.md
# Digital Input Sampling Controller

This block captures a parallel digital input port into a FIFO at a rate chosen by software. A single 32-bit control/status register sets the sampling mode and reports FIFO state. The register selects whether the captured word is 16 bits (port A only) or 32 bits (port A in the low half, port B in the high half). It also selects where sample ticks come from: an external timer tick, two clock enables divided down from the system clock, or rising edges of an external request strobe.

Sampling can be held off until a trigger input goes high after enable. An optional request/acknowledge handshake lets an external source pace the transfer. In that mode the block captures on each synchronized rising edge of the request line and answers with a one-cycle acknowledge once the word is in the FIFO. The register reports FIFO full, FIFO empty and a sticky overrun flag. A self-clearing clear bit empties the FIFO and resets the overrun flag. The terminator control bit is storage only.

Top module: `dig_in_sampler`

## Requirements
- R1: After reset the control/status register reads 0x0000_1000 (only the empty flag, bit 12, set) and the acknowledge output is low.
- R2: Register bits 0 (wide mode), 2:1 (source select), 3 (handshake), 5 (wait for trigger), 6 (terminator off) and 8 (enable) read back what was written. Bits 4, 7, 9 and 13 to 31 always read 0, and write data bits 31:16 have no effect.
- R3: Bits 10 (overrun), 11 (full) and 12 (empty) are read-only status, and writing them changes nothing. Full and empty are never set together.
- R4: Source select 00 samples on each timer_tick cycle, 01 once every FAST_DIV system cycles, 10 once every SLOW_DIV system cycles, and 11 on each synchronized rising edge of req_in. With select 11 and handshake off, no acknowledge is given.
- R5: With bit 0 clear the stored word is {16'h0000, porta}. With bit 0 set it is {portb, porta}.
- R6: With bit 5 set, ticks after enable are dropped until trig_in is seen high. After that, sampling continues while enable stays set, even once trig_in falls.
- R7: With enable clear, no sample is stored. Clearing enable and setting it again with bit 5 set requires a new trigger.
- R8: A tick that arrives while the FIFO holds FIFO_DEPTH words is dropped and sets the overrun flag. The flag stays set until a clear, even after the FIFO is read.
- R9: Writing 1 to bit 9 empties the FIFO and clears the overrun flag.
- R10: With bit 3 set, a rising edge on req_in is stored on the third clock edge after it is presented, and ack_out is high for exactly that following cycle. While the FIFO is full, ack_out stays low.
- R11: Words leave the FIFO in the order they were stored. A one-cycle fifo_rd pulse places the oldest word on fifo_rdata after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered register read value |
| timer_tick | input | 1 | One-cycle tick from an external timer |
| porta | input | HALF_W | Low input half |
| portb | input | HALF_W | High input half, used in wide mode |
| trig_in | input | 1 | Start trigger, synchronous, active high |
| req_in | input | 1 | External request strobe, asynchronous |
| ack_out | output | 1 | Handshake acknowledge pulse |
| fifo_rd | input | 1 | Pop one word from the FIFO |
| fifo_rdata | output | 2*HALF_W | Word popped on the previous cycle |

## Verification
The bench measures the divided sources over windows exactly four periods long. A divider that is off by one then shows up as three or five stored words instead of four. It counts the cycles from request to acknowledge, so a missing synchronizer stage or an acknowledge that fires before the FIFO write moves the pulse to the wrong cycle. It fills the FIFO and pushes one more tick: a design that overwrites the oldest entry or lets the pointers wrap returns a wrong 16th word, and one that clears overrun on a read loses the sticky flag. It also pulses the trigger and then drops it, which catches a trigger that is level-gated rather than latched, and it writes all ones to the status positions, which catches writable status bits.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int B_WIDE   = 0;
  localparam int B_SEL_LO = 1;
  localparam int B_HS     = 3;
  localparam int B_WAIT   = 5;
  localparam int B_TERM   = 6;
  localparam int B_EN     = 8;
  localparam int B_CLR    = 9;
  localparam int B_OVR    = 10;
  localparam int B_FULL   = 11;
  localparam int B_EMPTY  = 12;

  typedef enum logic [1:0] {
    SRC_TIMER = 2'b00,
    SRC_FAST  = 2'b01,
    SRC_SLOW  = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;

  typedef struct packed {
    logic term_off;
    logic wait_trig;
    logic hs;
    src_e sel;
    logic wide;
    logic en;
  } ctl_t;
endpackage

// File: rtl/dis_rate_gen.sv
module dis_rate_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dis_sync_edge.sv
module dis_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      last <= 1'b0;
    end else begin
      sr[0] <= din;
      last  <= sr[STAGES-1];
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sr[i] <= 1'b0;
      else     sr[i] <= sr[i-1];
    end
  end

  assign rise = sr[STAGES-1] & ~last;
endmodule

// File: rtl/dis_fifo.sv
module dis_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

  always_ff @(posedge clk) begin
    if (wr && !full) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (rd && !empty)  rdata <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr && !full) wp <= wp + 1'b1;
      if (rd && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/dig_in_sampler.sv
module dig_in_sampler
  import dis_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int FAST_DIV    = 4,
  parameter int SLOW_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csr_wr,
  input  logic [31:0]         csr_wdata,
  output logic [31:0]         csr_rdata,
  input  logic                timer_tick,
  input  logic [HALF_W-1:0]   porta,
  input  logic [HALF_W-1:0]   portb,
  input  logic                trig_in,
  input  logic                req_in,
  output logic                ack_out,
  input  logic                fifo_rd,
  output logic [2*HALF_W-1:0] fifo_rdata
);
  localparam int WORD_W = 2 * HALF_W;

  ctl_t              ctl_q;
  logic              armed_q;
  logic              ovr_q;
  logic              clr_pulse;
  logic              fast_tick, slow_tick, req_rise;
  logic              sel_tick, src_tick, smp_go, smp_wr;
  logic              fifo_full, fifo_empty;
  logic [WORD_W-1:0] word;
  logic              unused_bits;

  assign unused_bits = ^{csr_wdata[31:10], csr_wdata[7], csr_wdata[4]};
  assign clr_pulse   = csr_wr & csr_wdata[B_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (csr_wr) begin
      ctl_q.en        <= csr_wdata[B_EN];
      ctl_q.wide      <= csr_wdata[B_WIDE];
      ctl_q.sel       <= src_e'(csr_wdata[B_SEL_LO +: 2]);
      ctl_q.hs        <= csr_wdata[B_HS];
      ctl_q.wait_trig <= csr_wdata[B_WAIT];
      ctl_q.term_off  <= csr_wdata[B_TERM];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= ctl_q.en & (armed_q | ~ctl_q.wait_trig | trig_in);
  end

  dis_rate_gen #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst(rst), .tick(fast_tick));
  dis_rate_gen #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst(rst), .tick(slow_tick));
  dis_sync_edge #(.STAGES(SYNC_STAGES)) u_req (
    .clk(clk), .rst(rst), .din(req_in), .rise(req_rise)
  );

  always_comb begin
    unique case (ctl_q.sel)
      SRC_TIMER: sel_tick = timer_tick;
      SRC_FAST:  sel_tick = fast_tick;
      SRC_SLOW:  sel_tick = slow_tick;
      default:   sel_tick = req_rise;
    endcase
  end

  assign src_tick = ctl_q.hs ? req_rise : sel_tick;
  assign smp_go   = src_tick & ctl_q.en & armed_q & ~clr_pulse;
  assign smp_wr   = smp_go & ~fifo_full;
  assign word     = ctl_q.wide ? {portb, porta} : {{HALF_W{1'b0}}, porta};

  dis_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(clr_pulse),
    .wr(smp_wr), .wdata(word),
    .rd(fifo_rd), .rdata(fifo_rdata),
    .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_pulse)         ovr_q <= 1'b0;
    else if (smp_go && fifo_full) ovr_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ack_out <= 1'b0;
    else     ack_out <= smp_wr & ctl_q.hs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else begin
      csr_rdata                    <= '0;
      csr_rdata[B_WIDE]            <= ctl_q.wide;
      csr_rdata[B_SEL_LO +: 2]     <= ctl_q.sel;
      csr_rdata[B_HS]              <= ctl_q.hs;
      csr_rdata[B_WAIT]            <= ctl_q.wait_trig;
      csr_rdata[B_TERM]            <= ctl_q.term_off;
      csr_rdata[B_EN]              <= ctl_q.en;
      csr_rdata[B_OVR]             <= ovr_q;
      csr_rdata[B_FULL]            <= fifo_full;
      csr_rdata[B_EMPTY]           <= fifo_empty;
    end
  end
endmodule

// File: rtl/dis_checker.sv
module dis_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic wr,
  input logic ovr,
  input logic clr,
  input logic full,
  input logic empty,
  input logic ack
);
  assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_no_sample_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !en |-> !wr);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovr && !clr) |=> ovr);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (empty && !ovr));

  assert_ack_follows_write_R10: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(wr));

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
endmodule

bind dig_in_sampler dis_checker u_chk (
  .clk(clk), .rst(rst), .en(ctl_q.en), .wr(smp_wr), .ovr(ovr_q),
  .clr(clr_pulse), .full(fifo_full), .empty(fifo_empty), .ack(ack_out)
);

// File: tb/dig_in_sampler_tb.sv
module dig_in_sampler_tb;
  localparam int HALF_W = 16;
  localparam int DEPTH  = 16;
  localparam int FDIV   = 4;
  localparam int SDIV   = 8;
  localparam logic [31:0] EN   = 32'h100;
  localparam logic [31:0] CLR  = 32'h200;
  localparam logic [31:0] WIDE = 32'h1;
  localparam logic [31:0] HS   = 32'h8;
  localparam logic [31:0] WT   = 32'h20;
  localparam logic [31:0] SFAST = 32'h2;
  localparam logic [31:0] SSLOW = 32'h4;
  localparam logic [31:0] SEXT  = 32'h6;

  localparam int NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_FFFF, 32'h0000_116F},
    {32'hFFFF_0000, 32'h0000_1000},
    {32'h0000_0055, 32'h0000_1045},
    {32'h0000_1C00, 32'h0000_1000},
    {32'h0000_00AA, 32'h0000_102A},
    {32'h0000_0480, 32'h0000_1000}
  };

  logic clk = 0, rst = 1;
  logic csr_wr = 0, timer_tick = 0, trig_in = 0, req_in = 0, fifo_rd = 0;
  logic [31:0] csr_wdata = '0;
  logic [HALF_W-1:0] porta = '0, portb = '0;
  logic [31:0] csr_rdata, fifo_rdata;
  logic ack_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dig_in_sampler #(.HALF_W(HALF_W), .FIFO_DEPTH(DEPTH), .FAST_DIV(FDIV), .SLOW_DIV(SDIV)) u_dut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .timer_tick(timer_tick), .porta(porta), .portb(portb), .trig_in(trig_in),
    .req_in(req_in), .ack_out(ack_out), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_csr(input logic [31:0] v);
    @(negedge clk); csr_wr = 1; csr_wdata = v;
    @(negedge clk); csr_wr = 0; csr_wdata = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic tick(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); porta = a; portb = b; timer_tick = 1;
    @(negedge clk); timer_tick = 0;
  endtask

  task automatic pop(input string req, input logic [31:0] exp);
    @(negedge clk); fifo_rd = 1;
    @(negedge clk); fifo_rd = 0;
    chk(req, fifo_rdata, exp);
  endtask

  task automatic drain_count(output int n);
    n = 0;
    settle();
    for (int i = 0; i < DEPTH + 4; i++) begin
      if (csr_rdata[12]) break;
      @(negedge clk); fifo_rd = 1;
      @(negedge clk); fifo_rd = 0;
      n++;
      settle();
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
    chk("R1 csr reset", csr_rdata, 32'h0000_1000);
    chk("R1 ack reset", {31'b0, ack_out}, 32'h0);

    // R2 / R3 vector walk
    for (int i = 0; i < NV; i++) begin
      wr_csr(VEC[i][63:32]);
      settle();
      chk(i == 3 || i == 5 ? "R3 status write" : "R2 readback", csr_rdata, VEC[i][31:0]);
    end
    wr_csr(CLR); settle();

    // R4 timer source, R5 narrow, R11 order
    wr_csr(EN);
    tick(16'h1111, 16'hAAAA);
    tick(16'h2222, 16'hBBBB);
    tick(16'h3333, 16'hCCCC);
    wr_csr(0);
    pop("R11 first",  32'h0000_1111);
    pop("R11 second", 32'h0000_2222);
    pop("R4 timer third", 32'h0000_3333);
    settle();
    chk("R11 empty after drain", csr_rdata & 32'h1C00, 32'h1000);

    // R5 wide
    wr_csr(EN | WIDE);
    tick(16'h1234, 16'hABCD);
    wr_csr(0);
    pop("R5 wide word", 32'hABCD_1234);

    // R4 fast and slow windows of exactly four periods
    wr_csr(EN | SFAST);
    repeat (4 * FDIV - 1) @(negedge clk);
    wr_csr(0);
    drain_count(n);
    chk("R4 fast count", n, 4);
    wr_csr(EN | SSLOW);
    repeat (4 * SDIV - 1) @(negedge clk);
    wr_csr(0);
    drain_count(n);
    chk("R4 slow count", n, 4);

    // R4 external source without handshake
    wr_csr(EN | SEXT);
    @(negedge clk); porta = 16'h0E0E; req_in = 1;
    n = 0;
    repeat (5) begin @(negedge clk); if (ack_out) n++; end
    req_in = 0;
    chk("R4 ext no ack", n, 0);
    wr_csr(0);
    pop("R4 ext sample", 32'h0000_0E0E);

    // R6 trigger
    wr_csr(EN | WT);
    tick(16'h0BAD, 0);
    tick(16'h0BAD, 0);
    settle();
    chk("R6 held before trigger", csr_rdata & 32'h1C00, 32'h1000);
    @(negedge clk); trig_in = 1;
    @(negedge clk); trig_in = 0;
    tick(16'h6001, 0);
    tick(16'h6002, 0);
    wr_csr(0);
    pop("R6 armed first", 32'h0000_6001);
    pop("R6 armed stays", 32'h0000_6002);

    // R7 disabled, then re-enable with wait
    tick(16'h7777, 0);
    settle();
    chk("R7 disabled no sample", csr_rdata & 32'h1C00, 32'h1000);
    wr_csr(EN | WT);
    tick(16'h7778, 0);
    settle();
    chk("R7 rearm needs trigger", csr_rdata & 32'h1C00, 32'h1000);
    wr_csr(0);

    // R8 overrun
    wr_csr(EN);
    for (int i = 0; i < DEPTH; i++) tick(16'h0100 + 16'(i), 0);
    tick(16'hDEAD, 0);
    wr_csr(0); settle();
    chk("R8 full and overrun", csr_rdata & 32'h1C00, 32'h0C00);
    for (int i = 0; i < DEPTH; i++) pop("R8 kept data", 32'h0000_0100 + 32'(i));
    settle();
    chk("R8 overrun sticky", csr_rdata & 32'h1C00, 32'h1400);

    // R9 clear
    wr_csr(CLR); settle();
    chk("R9 clear overrun", csr_rdata, 32'h0000_1000);
    wr_csr(EN);
    tick(16'h9999, 0);
    wr_csr(EN | CLR); settle();
    chk("R9 clear with data", csr_rdata & 32'h1E00, 32'h1000);
    wr_csr(0);

    // R10 handshake timing
    wr_csr(EN | HS);
    @(negedge clk); porta = 16'h55AA; portb = 16'h1234; req_in = 1;
    @(negedge clk); chk("R10 ack cycle1", {31'b0, ack_out}, 0);
    @(negedge clk); chk("R10 ack cycle2", {31'b0, ack_out}, 0);
    @(negedge clk); chk("R10 ack cycle3", {31'b0, ack_out}, 1);
    @(negedge clk); chk("R10 ack cycle4", {31'b0, ack_out}, 0);
    req_in = 0;
    wr_csr(0);
    pop("R10 hs data", 32'h0000_55AA);

    // R10 ack withheld while full
    wr_csr(EN);
    for (int i = 0; i < DEPTH; i++) tick(16'(i), 0);
    wr_csr(EN | HS);
    @(negedge clk); req_in = 1;
    n = 0;
    repeat (6) begin @(negedge clk); if (ack_out) n++; end
    req_in = 0;
    chk("R10 no ack when full", n, 0);
    settle();
    chk("R10 overrun on full", csr_rdata & 32'h1C00, 32'h0C00);
    wr_csr(CLR);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule